// File: doc/BRIEF.md
# Wide Bus Address Capture for Single and Dual Address Cycles

This block sits on the target side of a 32-bit parallel bus that uses an active-low frame signal. It watches the start of each transaction and builds a 44-bit memory address. A transaction normally carries its address in one clock. A transaction that reaches above the 4 GB boundary instead uses two address clocks. It marks the first of them with a reserved command code, sends the low word on that clock, and sends the high bits, right-justified, together with the real bus command on the next clock.

The decoder gives one registered strobe per transaction. With the strobe come the full address, the command it reports, and a flag that tells whether the address took two clocks. Two-clock addressing is only allowed when the requester is permitted to use it. A per-requester enable input carries that permission, and it is held low for internal masters. When a blocked requester tries a two-clock address, the decoder gives a one-clock reject pulse and no address strobe. The decoder then ignores the rest of that transaction.

Top module: `wide_addr_decode`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `addr_vld`, `dual_reject`, `is_dual`, `addr` and `cmd` are all zero.
- R2: When the first clock of a transaction (the first clock with `frame_n` low after idle) carries a `cbe_n` value other than 4'b1101, `addr_vld` is high in the next cycle. In that cycle `addr` is {12'b0, first-clock `ad`}, `cmd` is the first-clock `cbe_n`, and `is_dual` is 0.
- R3: When the first clock carries `cbe_n` = 4'b1101 and `dual_en` = 1, there is no strobe in the next cycle. `addr_vld` is high in the cycle after the second clock. In that cycle `addr[31:0]` is the first-clock `ad`, `addr[43:32]` is the second-clock `ad[11:0]`, and `is_dual` is 1.
- R4: For a two-clock address, `cmd` is the `cbe_n` value of the second clock, not the code 4'b1101.
- R5: `ad[31:12]` on the second clock of a two-clock address has no effect on any output and raises no error.
- R6: When the first clock carries 4'b1101 and `dual_en` = 0, `dual_reject` is high for exactly the next cycle. No `addr_vld` strobe is issued for that transaction, and `addr`, `cmd` and `is_dual` keep their earlier values.
- R7: `addr_vld` is high for one cycle only, and at most once per transaction. Data-phase values on `ad` and `cbe_n`, including 4'b1101, are never decoded as an address while `frame_n` stays low.
- R8: A new transaction is recognised on the first clock with `frame_n` low after at least one clock with `frame_n` high.
- R9: `dual_en` is sampled only on the first address clock. Its value on the second clock does not change the result.
- R10: `addr`, `cmd` and `is_dual` change only in a cycle where `addr_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_n | input | 1 | Active-low transaction frame |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command / byte-enable lines |
| dual_en | input | 1 | Current requester may use two-clock addressing |
| addr_vld | output | 1 | One-cycle address strobe |
| addr | output | 44 | Assembled address |
| cmd | output | 4 | Reported bus command |
| is_dual | output | 1 | Address used two clocks |
| dual_reject | output | 1 | One-cycle pulse: blocked two-clock attempt |

## Verification
The assertions assume well-formed bus framing. `frame_n` stays low through both address clocks of a two-clock address. Every transaction stays open for at least one data phase, and `frame_n` goes high for at least one clock between transactions. The directed stimulus always drives `frame_n` high for one idle clock after each transaction. It keeps the frame low across both address clocks and at least one data phase. It places the reserved code and changing values on `ad` during data phases to check that they are not decoded. One scenario asserts reset in the middle of a transaction while the frame is released, so the assumed framing still holds when reset is released.

// File: rtl/wad_pkg.sv
package wad_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_BUSY = 2'd2
  } phase_e;

  // command value that flags a two-clock address on the first clock
  localparam logic [3:0] DUAL_CODE = 4'b1101;
endpackage

// File: rtl/wad_phase_fsm.sv
module wad_phase_fsm
  import wad_pkg::*;
#(
  parameter int CMD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [CMD_W-1:0] cbe_n,
  input  logic             dual_en,
  output logic             cap_single,
  output logic             cap_low,
  output logic             cap_high,
  output logic             reject
);
  phase_e st_q, st_d;
  logic   first_clk;
  logic   is_code;

  always_comb begin
    first_clk  = (st_q == PH_IDLE) && !frame_n;
    is_code    = (cbe_n == DUAL_CODE);
    cap_single = first_clk && !is_code;
    cap_low    = first_clk && is_code && dual_en;
    reject     = first_clk && is_code && !dual_en;
    cap_high   = (st_q == PH_HIGH);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_IDLE: if (first_clk) st_d = cap_low ? PH_HIGH : PH_BUSY;
      PH_HIGH: st_d = PH_BUSY;
      PH_BUSY: if (frame_n) st_d = PH_IDLE;
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PH_IDLE;
    else        st_q <= st_d;
  end

  // R3: second address clock only ever follows an accepted first clock
  a_r3_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_HIGH) |-> $past(cap_low));

  // R8: a frame held low never reopens the idle phase
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PH_BUSY) && !frame_n) |=> (st_q == PH_BUSY));
endmodule

// File: rtl/wad_addr_reg.sv
module wad_addr_reg #(
  parameter int ADDR_W = 44,
  parameter int AD_W   = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AD_W-1:0]   ad,
  input  logic [CMD_W-1:0]  cbe_n,
  input  logic              cap_single,
  input  logic              cap_low,
  input  logic              cap_high,
  input  logic              reject,
  output logic              addr_vld,
  output logic [ADDR_W-1:0] addr,
  output logic [CMD_W-1:0]  cmd,
  output logic              is_dual,
  output logic              dual_reject
);
  localparam int HI_W = ADDR_W - AD_W;

  logic [AD_W-1:0]   lo_hold_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CMD_W-1:0]  cmd_q;
  logic              vld_q, dual_q, rej_q;
  logic              commit;

  always_comb begin
    commit = cap_single || cap_high;
    if (cap_high) addr_d = {ad[HI_W-1:0], lo_hold_q};
    else          addr_d = {{HI_W{1'b0}}, ad};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_hold_q <= '0;
    else if (cap_low) lo_hold_q <= ad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
      dual_q <= 1'b0;
    end else if (commit) begin
      addr_q <= addr_d;
      cmd_q  <= cbe_n;
      dual_q <= cap_high;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      vld_q <= commit;
      rej_q <= reject;
    end
  end

  assign addr_vld    = vld_q;
  assign addr        = addr_q;
  assign cmd         = cmd_q;
  assign is_dual     = dual_q;
  assign dual_reject = rej_q;

  // R2: one-clock address lands zero-extended with its own command
  a_r2_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_single |=> (addr_vld && !is_dual && addr == {{HI_W{1'b0}}, $past(ad)}
                    && cmd == $past(cbe_n)));

  // R3, R4: high bits and command come from the second clock
  a_r3_dual_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_high |=> (addr_vld && is_dual && addr[ADDR_W-1:AD_W] == $past(ad[HI_W-1:0])
                  && cmd == $past(cbe_n)));

  // R6: a reject never coincides with a strobe and lasts one cycle
  a_r6_reject_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dual_reject |-> !addr_vld);
  a_r6_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dual_reject |=> !dual_reject);

  // R7: strobe is a single-cycle pulse
  a_r7_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> !addr_vld);

  // R10: outputs hold between strobes
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |-> ($stable(addr) && $stable(cmd) && $stable(is_dual)));
endmodule

// File: rtl/wide_addr_decode.sv
module wide_addr_decode #(
  parameter int ADDR_W = 44,
  parameter int AD_W   = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [AD_W-1:0]   ad,
  input  logic [CMD_W-1:0]  cbe_n,
  input  logic              dual_en,
  output logic              addr_vld,
  output logic [ADDR_W-1:0] addr,
  output logic [CMD_W-1:0]  cmd,
  output logic              is_dual,
  output logic              dual_reject
);
  logic cap_single, cap_low, cap_high, reject;

  wad_phase_fsm #(.CMD_W(CMD_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .cbe_n      (cbe_n),
    .dual_en    (dual_en),
    .cap_single (cap_single),
    .cap_low    (cap_low),
    .cap_high   (cap_high),
    .reject     (reject)
  );

  wad_addr_reg #(.ADDR_W(ADDR_W), .AD_W(AD_W), .CMD_W(CMD_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ad          (ad),
    .cbe_n       (cbe_n),
    .cap_single  (cap_single),
    .cap_low     (cap_low),
    .cap_high    (cap_high),
    .reject      (reject),
    .addr_vld    (addr_vld),
    .addr        (addr),
    .cmd         (cmd),
    .is_dual     (is_dual),
    .dual_reject (dual_reject)
  );

  // R1: nothing is reported in the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!addr_vld && !dual_reject));
endmodule

// File: tb/sim_wide_addr_decode.sv
module sim_wide_addr_decode;
  localparam int ADDR_W = 44;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic        dual_en;
  logic        addr_vld;
  logic [ADDR_W-1:0] addr;
  logic [3:0]  cmd;
  logic        is_dual;
  logic        dual_reject;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [ADDR_W-1:0] exp_addr;
  logic [3:0]        exp_cmd;
  logic              exp_dual;

  always #2.5 clk = ~clk;

  wide_addr_decode u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
    .dual_en(dual_en), .addr_vld(addr_vld), .addr(addr), .cmd(cmd),
    .is_dual(is_dual), .dual_reject(dual_reject)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req, input logic vld, input logic rej);
    chk(addr_vld == vld, {req, " addr_vld"}, 64'(addr_vld), 64'(vld));
    chk(dual_reject == rej, {req, " dual_reject"}, 64'(dual_reject), 64'(rej));
    chk(addr == exp_addr, {req, " addr"}, 64'(addr), 64'(exp_addr));
    chk(cmd == exp_cmd, {req, " cmd"}, 64'(cmd), 64'(exp_cmd));
    chk(is_dual == exp_dual, {req, " is_dual"}, 64'(is_dual), 64'(exp_dual));
  endtask

  task automatic end_txn(input string req);
    frame_n = 1'b1; ad = '0; cbe_n = 4'hF;
    @(negedge clk);
    chk_outs(req, 1'b0, 1'b0);
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0; frame_n = 1'b1; ad = '0; cbe_n = 4'hF; dual_en = 1'b0;
    repeat (3) @(negedge clk);
    exp_addr = '0; exp_cmd = '0; exp_dual = 1'b0;
    chk_outs("R1 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R1 after release", 1'b0, 1'b0);
  endtask

  // R2, R7, R8
  task automatic t_single(input logic [31:0] lo, input logic [3:0] c);
    frame_n = 1'b0; ad = lo; cbe_n = c; dual_en = 1'b1;
    @(negedge clk);
    exp_addr = {12'h000, lo}; exp_cmd = c; exp_dual = 1'b0;
    chk_outs("R2 single strobe", 1'b1, 1'b0);
    ad = ~lo; cbe_n = 4'b1101;
    @(negedge clk);
    chk_outs("R7 data phase no strobe", 1'b0, 1'b0);
    end_txn("R8 idle gap");
  endtask

  // R3, R4, R5, R9
  task automatic t_dual(input logic [31:0] lo, input logic [31:0] hi_raw,
                        input logic [3:0] c, input logic en2);
    frame_n = 1'b0; ad = lo; cbe_n = 4'b1101; dual_en = 1'b1;
    @(negedge clk);
    chk_outs("R3 no strobe on first clock", 1'b0, 1'b0);
    ad = hi_raw; cbe_n = c; dual_en = en2;
    @(negedge clk);
    exp_addr = {hi_raw[11:0], lo}; exp_cmd = c; exp_dual = 1'b1;
    chk_outs("R3 R4 R5 R9 dual strobe", 1'b1, 1'b0);
    ad = 32'hDEAD_BEEF; cbe_n = 4'b1101;
    @(negedge clk);
    chk_outs("R7 dual data phase", 1'b0, 1'b0);
    end_txn("R8 dual idle gap");
  endtask

  // R6
  task automatic t_blocked(input logic [31:0] lo);
    frame_n = 1'b0; ad = lo; cbe_n = 4'b1101; dual_en = 1'b0;
    @(negedge clk);
    chk_outs("R6 reject pulse", 1'b0, 1'b1);
    ad = 32'h0000_0ABC; cbe_n = 4'b0111; dual_en = 1'b1;
    @(negedge clk);
    chk_outs("R6 no strobe after reject", 1'b0, 1'b0);
    ad = 32'h1234_5678; cbe_n = 4'b0110;
    @(negedge clk);
    chk_outs("R6 rest ignored", 1'b0, 1'b0);
    end_txn("R6 idle gap");
  endtask

  // R7: long burst with the reserved code on the data lines
  task automatic t_long_burst();
    frame_n = 1'b0; ad = 32'h0000_4000; cbe_n = 4'b0111; dual_en = 1'b1;
    @(negedge clk);
    exp_addr = {12'h000, 32'h0000_4000}; exp_cmd = 4'b0111; exp_dual = 1'b0;
    chk_outs("R7 burst strobe", 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      ad = 32'hA5A5_0000 + 32'(i); cbe_n = 4'b1101;
      @(negedge clk);
      chk_outs("R7 burst data", 1'b0, 1'b0);
    end
    end_txn("R7 burst end");
  endtask

  // R1: reset in the middle of a two-clock address
  task automatic t_mid_reset();
    frame_n = 1'b0; ad = 32'h7777_0000; cbe_n = 4'b1101; dual_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; frame_n = 1'b1; ad = '0; cbe_n = 4'hF;
    @(negedge clk);
    exp_addr = '0; exp_cmd = '0; exp_dual = 1'b0;
    chk_outs("R1 mid-transaction reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R1 quiet after mid reset", 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_single(32'h1234_5678, 4'b0110);
    t_single(32'hFFFF_FFFC, 4'b0111);
    t_single(32'h0000_0000, 4'b1100);
    t_dual(32'h89AB_CDEF, 32'h0000_0FFF, 4'b0110, 1'b1);
    t_dual(32'h0000_1000, 32'hFFFF_F123, 4'b0111, 1'b0);
    t_blocked(32'h5555_AAAA);
    t_long_burst();
    t_dual(32'hFFFF_FFFF, 32'h0000_0001, 4'b1110, 1'b1);
    t_mid_reset();
    t_single(32'h0BAD_F00D, 4'b1111);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule